// File: doc/BRIEF.md
# Page-Hit-Aware DRAM Write Buffer

This block sits between a stream of memory requests and the command slot of a DRAM controller. It tracks which row is open in every bank (open-page policy) and uses that to decide each request's fate. A write aimed at an open row is sent straight out as a column write. A write that would force a row change is parked in a small ordered buffer. Reads are never parked: a read is accepted as soon as the command slot is free, and it opens its row itself with precharge and activate commands as needed.

Right after a read has activated a row, the block issues every parked write for that bank and row, one per cycle and oldest first, while the row is still open. Parked writes therefore never cost an extra row change of their own. A read whose full address matches a parked write gets that write's data on a separate forwarding output. Two parked writes to the same address collapse into one entry, and the later data wins. If the buffer is full, the oldest entry is forced out with its own row change before the new write is taken. A flush input empties the buffer in arrival order. A row-closure input, pulsed by the refresh logic, marks all banks closed.

Top module: `pha_write_buffer`

## Requirements
- R1: After reset all banks are closed, the buffer is empty, `idle` is 1 and `cmd_valid` is 0.
- R2: A write whose bank and row match the open row of that bank is accepted and issued as a column write (`cmd_op` 3) in the same cycle. Nothing is buffered.
- R3: A write to a closed bank, or to a bank that has a different row open, is accepted without any command and is buffered. `idle` drops to 0 while any entry is buffered.
- R4: Command codes on `cmd_op` are 0 precharge, 1 activate, 2 read, 3 write. A read to a closed bank produces activate then read in consecutive cycles. A read to a bank with another row open produces precharge, activate, read. Read and write commands only target a row that is open.
- R5: In the cycles right after a read that activated a row, every buffered write for that bank and row is issued, one per cycle, in arrival order, and removed from the buffer.
- R6: A read is always accepted when no command sequence or drain is in progress. During a drain, a read to any currently open row is accepted and issued ahead of the remaining buffered writes.
- R7: During a drain, a read to the drained bank that targets a different row is not accepted until the drain has finished.
- R8: A read whose bank, row and column match a buffered write raises `fwd_valid` for one cycle in the cycle after acceptance, with that entry's data on `fwd_data`.
- R9: A buffered write that meets a new write to the same bank, row and column takes the new data, and no second entry is made.
- R10: With the buffer full, a missing write is held off (`req_ready` low) while the oldest entry is issued with the row change it needs. The write is then accepted into the freed space.
- R11: While `flush` is high and no request is offered, buffered writes are issued in arrival order with the row changes they need, and `idle` rises once the buffer is empty.
- R12: A pulse on `rows_closed` marks every bank closed. A later write to a previously open row is then buffered as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DATA_W | Write data |
| rows_closed | input | 1 | All rows were closed by refresh |
| flush | input | 1 | Drain every buffered write |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | 0 PRE, 1 ACT, 2 RD, 3 WR |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | Command column |
| cmd_wdata | output | DATA_W | Data for write commands |
| fwd_valid | output | 1 | Read data supplied from buffer |
| fwd_data | output | DATA_W | Forwarded write data |
| idle | output | 1 | No work in progress, buffer empty |

## Verification
The hardest case to reach is a full buffer facing one more missing write, because that needs the buffer filled to its very last entry with writes that can never hit. The stimulus first closes every row and then streams distinct rows into one closed bank, so nothing merges or drains before the overflow write arrives. A second hard case is a read offered in the middle of a drain. The bench issues it back to back behind the activating read, so it lands in the drain cycles and its place in the command log shows whether it was issued ahead of the buffered writes.

// File: rtl/pha_write_buffer.sv
module pha_write_buffer #(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rows_closed,
  input  logic              flush,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              fwd_valid,
  output logic [DATA_W-1:0] fwd_data,
  output logic              idle
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [1:0] OP_PRE = 2'd0, OP_ACT = 2'd1, OP_RD = 2'd2, OP_WR = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_SEQ, S_DRAIN} st_t;
  st_t st, nst;

  logic [BANKS-1:0] tbl_v;
  logic [ROW_W-1:0] tbl_row [BANKS];

  logic [BANK_W-1:0] q_bank [DEPTH];
  logic [ROW_W-1:0]  q_row  [DEPTH];
  logic [COL_W-1:0]  q_col  [DEPTH];
  logic [DATA_W-1:0] q_data [DEPTH];
  logic [CNT_W-1:0]  cnt;

  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic [DATA_W-1:0] cur_data;
  logic              cur_q;

  logic [BANKS-1:0] open_v;
  logic req_hit, cur_open, full;
  logic m_any, d_any;
  logic [IDX_W-1:0] m_idx, d_idx, rm_idx;
  logic ins, mrg, ld_req, ld_head, rm, act, pre;

  assign open_v   = tbl_v & ~{BANKS{rows_closed}};
  assign req_hit  = open_v[req_bank] && tbl_row[req_bank] == req_row;
  assign cur_open = open_v[cur_bank] && tbl_row[cur_bank] == cur_row;
  assign full     = cnt == CNT_W'(DEPTH);
  assign idle     = st == S_IDLE && cnt == '0;

  always_comb begin
    m_any = 1'b0; m_idx = '0; d_any = 1'b0; d_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CNT_W'(i) < cnt && q_bank[i] == req_bank && q_row[i] == req_row && q_col[i] == req_col) begin
        m_any = 1'b1; m_idx = IDX_W'(i);
      end
      if (CNT_W'(i) < cnt && q_bank[i] == cur_bank && q_row[i] == cur_row) begin
        d_any = 1'b1; d_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    req_ready = 1'b0; cmd_valid = 1'b0; cmd_op = OP_RD;
    cmd_bank = req_bank; cmd_row = req_row; cmd_col = req_col; cmd_wdata = req_wdata;
    nst = st; ins = 1'b0; mrg = 1'b0; ld_req = 1'b0; ld_head = 1'b0;
    rm = 1'b0; rm_idx = '0; act = 1'b0; pre = 1'b0;
    case (st)
      S_IDLE:
        if (req_valid) begin
          if (req_hit) begin
            req_ready = 1'b1; cmd_valid = 1'b1; cmd_op = req_write ? OP_WR : OP_RD;
          end else if (!req_write) begin
            req_ready = 1'b1; ld_req = 1'b1; nst = S_SEQ;
          end else if (m_any) begin
            req_ready = 1'b1; mrg = 1'b1;
          end else if (!full) begin
            req_ready = 1'b1; ins = 1'b1;
          end else begin
            ld_head = 1'b1; nst = S_SEQ;
          end
        end else if (flush && cnt != '0) begin
          ld_head = 1'b1; nst = S_SEQ;
        end
      S_SEQ: begin
        cmd_valid = 1'b1; cmd_bank = cur_bank; cmd_row = cur_row;
        cmd_col = cur_col; cmd_wdata = cur_data;
        if (cur_open) begin
          cmd_op = cur_q ? OP_WR : OP_RD; rm = cur_q; nst = S_DRAIN;
        end else if (open_v[cur_bank]) begin
          cmd_op = OP_PRE; pre = 1'b1;
        end else begin
          cmd_op = OP_ACT; act = 1'b1;
        end
      end
      S_DRAIN:
        if (req_valid && !req_write && req_hit) begin
          req_ready = 1'b1; cmd_valid = 1'b1; cmd_op = OP_RD;
        end else if (d_any && cur_open) begin
          cmd_valid = 1'b1; cmd_op = OP_WR; cmd_bank = cur_bank; cmd_row = cur_row;
          cmd_col = q_col[d_idx]; cmd_wdata = q_data[d_idx]; rm = 1'b1; rm_idx = d_idx;
        end else begin
          nst = S_IDLE;
        end
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tbl_v <= '0; cnt <= '0; cur_q <= 1'b0;
      cur_bank <= '0; cur_row <= '0; cur_col <= '0; cur_data <= '0;
      for (int b = 0; b < BANKS; b++) tbl_row[b] <= '0;
      fwd_valid <= 1'b0; fwd_data <= '0;
    end else begin
      st <= nst;
      if (rows_closed) tbl_v <= '0;
      else if (pre) tbl_v[cur_bank] <= 1'b0;
      else if (act) begin
        tbl_v[cur_bank] <= 1'b1; tbl_row[cur_bank] <= cur_row;
      end
      if (ld_req) begin
        cur_bank <= req_bank; cur_row <= req_row; cur_col <= req_col;
        cur_data <= req_wdata; cur_q <= 1'b0;
      end else if (ld_head) begin
        cur_bank <= q_bank[0]; cur_row <= q_row[0]; cur_col <= q_col[0];
        cur_data <= q_data[0]; cur_q <= 1'b1;
      end
      if (ins) cnt <= cnt + CNT_W'(1);
      else if (rm) cnt <= cnt - CNT_W'(1);
      fwd_valid <= req_valid && req_ready && !req_write && m_any;
      fwd_data  <= q_data[m_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rm) begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (IDX_W'(i) >= rm_idx) begin
          q_bank[i] <= q_bank[i+1]; q_row[i] <= q_row[i+1];
          q_col[i] <= q_col[i+1]; q_data[i] <= q_data[i+1];
        end
    end else if (ins) begin
      q_bank[cnt[IDX_W-1:0]] <= req_bank; q_row[cnt[IDX_W-1:0]] <= req_row;
      q_col[cnt[IDX_W-1:0]] <= req_col; q_data[cnt[IDX_W-1:0]] <= req_wdata;
    end else if (mrg) begin
      q_data[m_idx] <= req_wdata;
    end
  end

  AST_COL_CMD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op[1] |-> tbl_v[cmd_bank] && !rows_closed && tbl_row[cmd_bank] == cmd_row); // R4
  AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_ACT |-> !tbl_v[cmd_bank] || rows_closed); // R4
  AST_PRE_OTHER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_PRE |-> tbl_v[cmd_bank] && tbl_row[cmd_bank] != cmd_row); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R10
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1) || cnt + CNT_W'(1) == $past(cnt)); // R5
  AST_READ_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && req_valid && !req_write |-> req_ready); // R6
  AST_FWD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> !fwd_valid || $past(req_valid && req_ready && !req_write)); // R8
endmodule

// File: tb/pha_write_buffer_test.sv
module pha_write_buffer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rows_closed = 1'b0, flush = 1'b0;
  logic [1:0] req_bank = '0;
  logic [7:0] req_row = '0;
  logic [3:0] req_col = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, cmd_valid, fwd_valid, idle;
  logic [1:0] cmd_op, cmd_bank;
  logic [7:0] cmd_row;
  logic [3:0] cmd_col;
  logic [15:0] cmd_wdata, fwd_data;

  pha_write_buffer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .rows_closed(rows_closed), .flush(flush),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_wdata(cmd_wdata), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .idle(idle));

  always #10 clk = ~clk;

  int cyc = 0, total = 0, bad = 0, log_n = 0, fwd_cnt = 0, acc_cyc = 0;
  logic [15:0] fwd_last;
  int l_op[512], l_bank[512], l_row[512], l_col[512], l_data[512], l_cyc[512];

  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (cmd_valid && log_n < 512) begin
      l_op[log_n] = cmd_op; l_bank[log_n] = cmd_bank; l_row[log_n] = cmd_row;
      l_col[log_n] = cmd_col; l_data[log_n] = cmd_wdata; l_cyc[log_n] = cyc;
      log_n++;
    end
    if (fwd_valid) begin fwd_cnt++; fwd_last = fwd_data; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_cmd(input string tag, input int i, input int op, input int b, input int r);
    chk({tag, " op"}, l_op[i], op);
    chk({tag, " bank"}, l_bank[i], b);
    chk({tag, " row"}, l_row[i], r);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send(input logic w, input logic [1:0] b, input logic [7:0] r,
                      input logic [3:0] c, input logic [15:0] d);
    int t = 0;
    req_write = w; req_bank = b; req_row = r; req_col = c; req_wdata = d; req_valid = 1'b1;
    do begin @(negedge clk); t++; end while (!req_ready && t < 2000);
    acc_cyc = cyc;
    @(posedge clk); #2 req_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 idle", idle, 1);
    chk("R1 cmd_valid", cmd_valid, 0);
    step(1);
  endtask

  task automatic t_read_open;
    log_n = 0;
    send(0, 0, 5, 1, 0); step(5);
    chk("R4 count closed", log_n, 2);
    chk_cmd("R4 act", 0, 1, 0, 5);
    chk_cmd("R4 rd", 1, 2, 0, 5);
    chk("R4 consecutive", l_cyc[1] - l_cyc[0], 1);
    log_n = 0;
    send(0, 0, 7, 1, 0); step(6);
    chk("R4 count conflict", log_n, 3);
    chk("R4 pre", l_op[0], 0);
    chk_cmd("R4 act2", 1, 1, 0, 7);
    chk_cmd("R4 rd2", 2, 2, 0, 7);
  endtask

  task automatic t_write_hit;
    log_n = 0;
    send(1, 0, 7, 2, 16'hAAAA); step(1);
    chk("R2 count", log_n, 1);
    chk_cmd("R2 wr", 0, 3, 0, 7);
    chk("R2 data", l_data[0], 16'hAAAA);
    chk("R2 same cycle", l_cyc[0], acc_cyc);
    chk("R2 idle", idle, 1);
  endtask

  task automatic t_buffer_fwd;
    int f0;
    log_n = 0;
    send(1, 1, 3, 0, 16'h1111);
    send(1, 1, 3, 0, 16'h2222);
    send(1, 1, 3, 5, 16'h3333);
    send(1, 2, 9, 1, 16'h4444);
    step(1);
    chk("R3 no cmd", log_n, 0);
    chk("R3 idle low", idle, 0);
    f0 = fwd_cnt;
    send(0, 1, 3, 0, 0); step(7);
    chk("R8 fwd count", fwd_cnt - f0, 1);
    chk("R8 fwd data", fwd_last, 16'h2222);
    chk("R9 merged count", log_n, 4);
    chk_cmd("R5 act", 0, 1, 1, 3);
    chk_cmd("R5 rd", 1, 2, 1, 3);
    chk_cmd("R5 wr0", 2, 3, 1, 3);
    chk("R9 later data", l_data[2], 16'h2222);
    chk("R5 order col", l_col[3], 5);
    chk("R5 wr1 data", l_data[3], 16'h3333);
    chk("R5 one per cycle", l_cyc[3] - l_cyc[1], 2);
  endtask

  task automatic t_read_in_drain;
    log_n = 0;
    send(1, 2, 9, 2, 16'h5555);
    send(1, 2, 9, 3, 16'h6666);
    send(0, 2, 9, 7, 0);
    send(0, 0, 7, 0, 0);
    step(8);
    chk("R6 count", log_n, 6);
    chk_cmd("R6 rd drained row", 1, 2, 2, 9);
    chk_cmd("R6 rd ahead", 2, 2, 0, 7);
    chk("R6 wr c1", l_data[3], 16'h4444);
    chk("R6 wr c2", l_data[4], 16'h5555);
    chk("R6 wr c3", l_data[5], 16'h6666);
    log_n = 0;
    send(1, 3, 1, 0, 16'h7777);
    send(1, 3, 1, 1, 16'h8888);
    send(0, 3, 1, 9, 0);
    send(0, 3, 2, 0, 0);
    step(8);
    chk("R7 count", log_n, 7);
    chk("R7 wr before pre a", l_op[2], 3);
    chk("R7 wr before pre b", l_op[3], 3);
    chk_cmd("R7 pre after drain", 4, 0, 3, 2);
    chk_cmd("R7 rd new row", 6, 2, 3, 2);
  endtask

  task automatic t_close_flush;
    int t = 0;
    rows_closed = 1'b1; step(1); rows_closed = 1'b0;
    log_n = 0;
    send(1, 0, 7, 4, 16'h9999);
    send(1, 1, 8, 0, 16'h0AA1);
    step(1);
    chk("R12 buffered", log_n, 0);
    chk("R12 idle low", idle, 0);
    flush = 1'b1;
    do begin @(negedge clk); t++; end while (!idle && t < 2000);
    step(1); flush = 1'b0;
    chk("R11 idle", idle, 1);
    chk("R11 count", log_n, 4);
    chk_cmd("R12 reopen", 0, 1, 0, 7);
    chk("R11 first data", l_data[1], 16'h9999);
    chk_cmd("R11 second act", 2, 1, 1, 8);
    chk("R11 second data", l_data[3], 16'h0AA1);
  endtask

  task automatic t_overflow;
    int t = 0, start, wrs = 0;
    log_n = 0;
    for (int i = 0; i < 64; i++) send(1, 2, 8'(10 + i), 0, 16'(16'h100 + i));
    step(1);
    chk("R10 fill no cmd", log_n, 0);
    start = cyc;
    send(1, 3, 200, 0, 16'hBEEF);
    chk("R10 held off", (acc_cyc - start >= 3) ? 1 : 0, 1);
    chk("R10 evict count", log_n, 2);
    chk_cmd("R10 evict act", 0, 1, 2, 10);
    chk_cmd("R10 evict wr", 1, 3, 2, 10);
    chk("R10 evict data", l_data[1], 16'h100);
    log_n = 0;
    flush = 1'b1;
    do begin @(negedge clk); t++; end while (!idle && t < 5000);
    step(1); flush = 1'b0;
    for (int i = 0; i < log_n; i++) if (l_op[i] == 3) wrs++;
    chk("R11 flush writes", wrs, 64);
    chk_cmd("R11 flush pre", 0, 0, 2, 11);
    chk("R11 flush first", l_data[2], 16'h101);
    chk_cmd("R11 last wr", log_n - 1, 3, 3, 200);
    chk("R11 last data", l_data[log_n - 1], 16'hBEEF);
    chk("R11 idle end", idle, 1);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset;
    t_read_open;
    t_write_hit;
    t_buffer_fwd;
    t_read_in_drain;
    t_close_flush;
    t_overflow;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule